// File: doc/BRIEF.md
# Serial Link Health Monitor

This block watches one serial receive link through three status lines: the optical module's signal-present flag, the deserializer's data-valid flag and its error flag. It resynchronises the lines into the core clock and sorts every sampled cycle into one of two groups. A cycle is either normal, or it is one of four fault kinds. Each fault kind sets a sticky flag. A 10-bit error counter, whose sources software selects, runs next to the flags.

A synchronisation idle restarts both the flags and the counter. An idle is a run of at least three consecutive samples with data-valid and error both low. When that run ends, the sample that ends it becomes the first cycle of a fresh accumulation window. The faults seen during the idle are discarded.

The same block holds the six transceiver control bits and drives them straight onto output pins. Software reaches everything through two 16-bit registers. The registers are selected by a one-bit address, written through a single-cycle write strobe and read combinationally.

Top module: `link_health_monitor`

## Requirements
- R1: While reset is held low, both registers read zero and all six control outputs are low.
- R2: Each status input passes through two register stages. A level applied before clock edge k shows in the live status bits of register 0 after edge k+1: bit 8 is signal-present, bit 9 is data-valid, bit 10 is error.
- R3: A synchronised sample with signal-present low sets the loss-of-signal flag (register 0 bit 12), whatever the other two lines show.
- R4: With signal-present high, a sample with data-valid low and error low sets the idle flag (bit 13). Data-valid low with error high sets the carrier-extend flag (bit 14). Data-valid high with error high sets the error-word flag (bit 15). Data-valid high with error low sets no flag.
- R5: Flags are sticky. A set flag stays set until the end of a synchronisation idle or reset.
- R6: At least three consecutive synchronised samples with data-valid and error both low form a synchronisation idle. On the first sample after such a run that is not idle, the flags and the counter restart from that sample's own contribution only. A run of two or fewer samples restarts nothing.
- R7: Register 1 holds the count in bits 9:0, read-only. Bit 12 enables counting of carrier-extend samples and bit 13 enables counting of error-word samples; both are read/write. With both bits set, both kinds of sample are counted. All other bits read zero.
- R8: The error counter stops at 1023 and does not wrap.
- R9: Register 0 bits 5:0 are read/write controls, driven straight onto the outputs: bit 0 transceiver enable, bit 1 transmit enable, bit 2 transmit error code, bit 3 loopback, bit 4 PRBS, bit 5 transmitter disable. Writes to bits 15:6 change nothing, and bits 11, 7 and 6 read zero.
- R10: Writing register 1 leaves the count in bits 9:0 unchanged, apart from what the link traffic adds in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_det_i | input | 1 | Optical signal-present flag, asynchronous |
| rx_valid_i | input | 1 | Deserializer data-valid flag, asynchronous |
| rx_err_i | input | 1 | Deserializer error flag, asynchronous |
| reg_we_i | input | 1 | Register write strobe, one cycle |
| reg_addr_i | input | 1 | Register select: 0 control/status, 1 error counter |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| xcvr_en_o | output | 1 | Transceiver enable |
| tx_en_o | output | 1 | Transmit enable |
| tx_err_o | output | 1 | Transmit error code |
| loop_en_o | output | 1 | Loopback enable |
| prbs_en_o | output | 1 | PRBS generator/checker enable |
| tx_dis_o | output | 1 | Optical transmitter disable |

## Verification
The assertions assume that the control registers change only on a write strobe. They also assume that, outside a synchronisation restart, the flags and the counter only grow, by at most one count per cycle. This means every status line is taken as a plain level that is sampled once per clock, and the assertions make no assumption about how the three lines relate to each other. The stimulus follows this: it changes the lines only on the inactive clock edge. It mixes normal traffic with loss-of-signal cycles, carrier-extend and error words, and idle runs of lengths around the three-sample threshold. This makes sure that both the restart path and the short-idle path are exercised.

// File: rtl/lhm_pkg.sv
// Shared types and field positions for the link health monitor.
// Assumes: a single link, three status lines, 16-bit registers.
package lhm_pkg;
    // one synchronised status sample
    typedef struct packed {
        logic er;   // error line
        logic dv;   // data-valid line
        logic sd;   // signal-present line
    } link_sample_t;

    // sticky fault flag indices
    localparam int FLT_LOS  = 0;
    localparam int FLT_IDLE = 1;
    localparam int FLT_CEXT = 2;
    localparam int FLT_ERRW = 3;
    localparam int FLT_NUM  = 4;

    // control bit count and register width
    localparam int CTL_W = 6;
    localparam int REG_W = 16;
endpackage

// File: rtl/lhm_sync.sv
// Two-stage level synchroniser for a bundle of asynchronous lines.
// Assumes: each line is a slow level; bits are not guaranteed coherent.
module lhm_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // shift the raw lines through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/lhm_fault_tracker.sv
// Classifies each synchronised sample, keeps sticky fault flags and a
// saturating error counter, and restarts both at the end of a sync idle.
// Assumes: one sample per clock; count enables come from the register block.
module lhm_fault_tracker
    import lhm_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int SYNC_RUN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  link_sample_t       smp_i,
    input  logic               cnt_cext_en_i,
    input  logic               cnt_errw_en_i,
    output logic [FLT_NUM-1:0] flags_o,
    output logic [CNT_W-1:0]   err_cnt_o
);
    localparam int             RUN_W    = $clog2(SYNC_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(SYNC_RUN);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [FLT_NUM-1:0] cur_flt;
    logic [FLT_NUM-1:0] flags_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [RUN_W-1:0]   run_q;
    logic               idle_now;
    logic               sync_end;
    logic               cnt_inc;

    // decode this cycle's fault class from the three lines
    always_comb begin
        cur_flt           = '0;
        cur_flt[FLT_LOS]  = ~smp_i.sd;
        cur_flt[FLT_IDLE] = smp_i.sd & ~smp_i.dv & ~smp_i.er;
        cur_flt[FLT_CEXT] = smp_i.sd & ~smp_i.dv &  smp_i.er;
        cur_flt[FLT_ERRW] = smp_i.sd &  smp_i.dv &  smp_i.er;
    end

    assign idle_now = ~smp_i.dv & ~smp_i.er;
    assign sync_end = ~idle_now & (run_q == RUN_FULL);
    assign cnt_inc  = (cnt_cext_en_i & cur_flt[FLT_CEXT]) |
                      (cnt_errw_en_i & cur_flt[FLT_ERRW]);

    // measure the current idle run, saturating at the sync threshold
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (!idle_now)    run_q <= '0;
        else if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
    end

    // accumulate sticky flags; restart from this sample at sync end
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= '0;
        else if (sync_end) flags_q <= cur_flt;
        else               flags_q <= flags_q | cur_flt;
    end

    // saturating error counter; restart from this sample at sync end
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (sync_end)                  cnt_q <= CNT_W'(cnt_inc);
        else if (cnt_inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign flags_o   = flags_q;
    assign err_cnt_o = cnt_q;

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_end |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5
    AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_end |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R7
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !sync_end) |=> cnt_q == CNT_MAX); // R8
    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_end |=> cnt_q <= CNT_W'(1)); // R6
endmodule

// File: rtl/lhm_regs.sv
// Register block: holds transceiver controls and count-source selects,
// and returns the addressed 16-bit register on a combinational read.
// Assumes: write strobe is one cycle wide; address is stable while reading.
module lhm_regs
    import lhm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic               addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  link_sample_t       smp_i,
    input  logic [FLT_NUM-1:0] flags_i,
    input  logic [CNT_W-1:0]   err_cnt_i,
    output logic [CTL_W-1:0]   ctrl_o,
    output logic               cnt_cext_en_o,
    output logic               cnt_errw_en_o,
    output logic [REG_W-1:0]   rdata_o
);
    localparam int SEL_CEXT = 12;
    localparam int SEL_ERRW = 13;

    logic [CTL_W-1:0] ctrl_q;
    logic [1:0]       sel_q;
    logic             wr_csr;
    logic             wr_cnt;
    logic             unused_wbits;

    assign wr_csr = we_i & ~addr_i;
    assign wr_cnt = we_i &  addr_i;
    assign unused_wbits = ^{wdata_i[15:14], wdata_i[11:CTL_W]};

    // control bits, written through register 0
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_csr) ctrl_q <= wdata_i[CTL_W-1:0];
    end

    // count-source selects, written through register 1
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_cnt) sel_q <= {wdata_i[SEL_ERRW], wdata_i[SEL_CEXT]};
    end

    // assemble the addressed register for reading
    always_comb begin
        rdata_o = '0;
        if (!addr_i) begin
            rdata_o[CTL_W-1:0] = ctrl_q;
            rdata_o[8]         = smp_i.sd;
            rdata_o[9]         = smp_i.dv;
            rdata_o[10]        = smp_i.er;
            rdata_o[15:12]     = flags_i;
        end else begin
            rdata_o[CNT_W-1:0] = err_cnt_i;
            rdata_o[SEL_CEXT]  = sel_q[0];
            rdata_o[SEL_ERRW]  = sel_q[1];
        end
    end

    assign ctrl_o        = ctrl_q;
    assign cnt_cext_en_o = sel_q[0];
    assign cnt_errw_en_o = sel_q[1];

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_csr |=> $stable(ctrl_q)); // R9
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> $stable(sel_q)); // R7
endmodule

// File: rtl/link_health_monitor.sv
// Top: synchronises the link status lines, tracks faults and errors,
// and exposes controls and status through two 16-bit registers.
// Assumes: status lines are asynchronous levels; one register access per cycle.
module link_health_monitor
    import lhm_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int SYNC_RUN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sig_det_i,
    input  logic        rx_valid_i,
    input  logic        rx_err_i,
    input  logic        reg_we_i,
    input  logic        reg_addr_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    output logic        xcvr_en_o,
    output logic        tx_en_o,
    output logic        tx_err_o,
    output logic        loop_en_o,
    output logic        prbs_en_o,
    output logic        tx_dis_o
);
    logic [2:0]         sync_bits;
    link_sample_t       smp;
    logic [FLT_NUM-1:0] flags;
    logic [CNT_W-1:0]   err_cnt;
    logic [CTL_W-1:0]   ctrl;
    logic               sel_cext;
    logic               sel_errw;

    lhm_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({rx_err_i, rx_valid_i, sig_det_i}),
        .sync_o  (sync_bits)
    );

    assign smp = link_sample_t'(sync_bits);

    lhm_fault_tracker #(.CNT_W(CNT_W), .SYNC_RUN(SYNC_RUN)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_i         (smp),
        .cnt_cext_en_i (sel_cext),
        .cnt_errw_en_i (sel_errw),
        .flags_o       (flags),
        .err_cnt_o     (err_cnt)
    );

    lhm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (reg_we_i),
        .addr_i        (reg_addr_i),
        .wdata_i       (reg_wdata_i),
        .smp_i         (smp),
        .flags_i       (flags),
        .err_cnt_i     (err_cnt),
        .ctrl_o        (ctrl),
        .cnt_cext_en_o (sel_cext),
        .cnt_errw_en_o (sel_errw),
        .rdata_o       (reg_rdata_o)
    );

    assign xcvr_en_o = ctrl[0];
    assign tx_en_o   = ctrl[1];
    assign tx_err_o  = ctrl[2];
    assign loop_en_o = ctrl[3];
    assign prbs_en_o = ctrl[4];
    assign tx_dis_o  = ctrl[5];
endmodule

// File: tb/tb_link_health_monitor.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a cycle model built from the requirements.
module tb_link_health_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_det_i = 1'b0, rx_valid_i = 1'b0, rx_err_i = 1'b0;
    logic        reg_we_i = 1'b0, reg_addr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        xcvr_en_o, tx_en_o, tx_err_o, loop_en_o, prbs_en_o, tx_dis_o;

    int compared = 0;
    int mismatched = 0;

    // reference model state: [0] sd, [1] dv, [2] er
    logic [2:0] m_s1 = '0, m_s2 = '0;
    logic [3:0] m_flags = '0;
    logic [9:0] m_cnt = '0;
    int         m_run = 0;
    logic [5:0] m_ctrl = '0;
    logic       m_cce = 1'b0, m_cerr = 1'b0;

    always #10 clk = ~clk;

    link_health_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .sig_det_i(sig_det_i), .rx_valid_i(rx_valid_i), .rx_err_i(rx_err_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .xcvr_en_o(xcvr_en_o), .tx_en_o(tx_en_o), .tx_err_o(tx_err_o),
        .loop_en_o(loop_en_o), .prbs_en_o(prbs_en_o), .tx_dis_o(tx_dis_o)
    );

    function automatic logic [15:0] exp_csr();
        return {m_flags, 1'b0, m_s2[2], m_s2[1], m_s2[0], 2'b00, m_ctrl};
    endfunction

    function automatic logic [15:0] exp_cnt();
        return {2'b00, m_cerr, m_cce, 2'b00, m_cnt};
    endfunction

    task automatic compare(input string tag, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        reg_addr_i = 1'b0; #1;
        compare(tag, "reg0", reg_rdata_o, exp_csr());
        reg_addr_i = 1'b1; #1;
        compare(tag, "reg1", reg_rdata_o, exp_cnt());
        compare(tag, "ctrl pins",
                {10'd0, tx_dis_o, prbs_en_o, loop_en_o, tx_err_o, tx_en_o, xcvr_en_o},
                {10'd0, m_ctrl});
    endtask

    // advance the model by one clock edge, from the requirements
    task automatic model_edge(input logic [2:0] inp, input logic we,
                              input logic adr, input logic [15:0] wd);
        logic sd, dv, er, idle_now, inc, sync_end;
        logic [3:0] cur;
        sd = m_s2[0]; dv = m_s2[1]; er = m_s2[2];
        cur = {sd & dv & er, sd & ~dv & er, sd & ~dv & ~er, ~sd};
        idle_now = ~dv & ~er;
        inc = (m_cce & cur[2]) | (m_cerr & cur[3]);
        sync_end = !idle_now && (m_run == 3);
        if (sync_end) begin
            m_flags = cur;
            m_cnt = {9'd0, inc};
        end else begin
            m_flags = m_flags | cur;
            if (inc && m_cnt != 10'd1023) m_cnt = m_cnt + 10'd1;
        end
        m_run = idle_now ? ((m_run == 3) ? 3 : m_run + 1) : 0;
        m_s2 = m_s1;
        m_s1 = inp;
        if (we && !adr) m_ctrl = wd[5:0];
        if (we && adr) begin
            m_cce = wd[12];
            m_cerr = wd[13];
        end
    endtask

    task automatic step(input logic sd, input logic dv, input logic er,
                        input logic we, input logic adr, input logic [15:0] wd,
                        input string tag);
        sig_det_i = sd; rx_valid_i = dv; rx_err_i = er;
        reg_we_i = we; reg_addr_i = adr; reg_wdata_i = wd;
        @(posedge clk);
        model_edge({er, dv, sd}, we, adr, wd);
        @(negedge clk);
        reg_we_i = 1'b0;
        check_all(tag);
    endtask

    task automatic run_n(input int n, input logic sd, input logic dv,
                         input logic er, input string tag);
        for (int i = 0; i < n; i++) step(sd, dv, er, 1'b0, 1'b0, 16'h0, tag);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        sig_det_i = 1'b1; rx_valid_i = 1'b1; rx_err_i = 1'b1;
        reg_we_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 16'hFFFF;
        repeat (3) @(negedge clk);
        reg_we_i = 1'b0;
        check_all("R1");                          // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;

        // start-up idle, then a long idle run and normal traffic
        run_n(5, 1'b1, 1'b0, 1'b0, "R6");
        run_n(4, 1'b1, 1'b1, 1'b0, "R6");        // R6 restart clears start-up flags

        // R9 control write, status bits in the write ignored
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFFEA, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0015, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h003F, "R9");

        // R2 latency of a one-cycle signal loss, then R3 flag
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R3");
        run_n(2, 1'b0, 1'b1, 1'b1, "R3");        // R3 loss with other lines high
        run_n(3, 1'b1, 1'b1, 1'b0, "R5");        // R5 flag stays set

        // R4 each class under signal present
        run_n(1, 1'b1, 1'b0, 1'b1, "R4");
        run_n(1, 1'b1, 1'b1, 1'b1, "R4");
        run_n(2, 1'b1, 1'b0, 1'b0, "R4");        // short idle: latched, no restart
        run_n(4, 1'b1, 1'b1, 1'b0, "R6");        // R6 run of two restarts nothing

        // R6 true sync idle, ended by a carrier-extend sample
        run_n(3, 1'b1, 1'b0, 1'b0, "R6");
        run_n(3, 1'b1, 1'b0, 1'b1, "R6");
        run_n(3, 1'b1, 1'b1, 1'b0, "R6");

        // R7 count sources
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2000, "R7");
        run_n(3, 1'b1, 1'b0, 1'b1, "R7");        // carrier extend not counted
        run_n(3, 1'b1, 1'b1, 1'b1, "R7");        // error words counted
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1000, "R7");
        run_n(2, 1'b1, 1'b1, 1'b1, "R7");
        run_n(2, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h3000, "R7");
        run_n(2, 1'b1, 1'b1, 1'b1, "R7");
        run_n(2, 1'b1, 1'b0, 1'b1, "R7");

        // R10 write of count bits ignored
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'hF3FF, "R10");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h3000, "R10");

        // R8 saturation
        run_n(1040, 1'b1, 1'b1, 1'b1, "R8");
        run_n(2, 1'b1, 1'b0, 1'b1, "R8");

        // sync restart of a saturated counter
        run_n(4, 1'b1, 1'b0, 1'b0, "R6");
        run_n(2, 1'b1, 1'b1, 1'b0, "R6");

        // seeded random traffic
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom % 16;
            if (r == 0) begin
                run_n(1, 1'b0, 1'($urandom), 1'($urandom), "RND");
            end else if (r <= 3) begin
                run_n(1 + ($urandom % 5), 1'($urandom % 4 != 0), 1'b0, 1'b0, "RND");
            end else if (r <= 5) begin
                run_n(1, 1'b1, 1'b0, 1'b1, "RND");
            end else if (r <= 7) begin
                run_n(1, 1'b1, 1'b1, 1'b1, "RND");
            end else if (r == 8) begin
                step(1'b1, 1'b1, 1'b0, 1'b1, 1'($urandom), 16'($urandom), "RND");
            end else begin
                run_n(1, 1'b1, 1'b1, 1'b0, "RND");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule